// File: doc/BRIEF.md
# Hypervisor-Aware Local Interrupt Selector

This block picks which local interrupt a hart should take in the current cycle. Its inputs are the pending, enable and delegation vectors, the current privilege level, a virtualization-mode flag and three global interrupt-enable bits. The first enable bit belongs to machine mode. The second belongs to the supervisor context that is active now. The third comes from the host supervisor's own status copy, which is not virtualized.

It returns three things: a valid flag, the cause index of the winning interrupt, and a flag that tells the trap logic to send the trap to the host supervisor and not to the guest. Guest-supervisor sources sit at bits 2, 6 and 10 of the vector. While the hart runs a guest, those bits are moved down by one bit so that they land on the supervisor slots.

The decision logic is purely combinational. An optional output register, selected by a parameter and on by default, lets the trap entry logic take the result from a flop. Trap entry, status updates and register access are done by the surrounding core.

Top module: `virt_irq_select`

## Requirements
- R1: While `rstN` is low, `irqValid`, `irqCause` and `forceHost` are all 0.
- R2: With `virtOn` low, the candidates are `pendVec & enableVec` with bits 2, 6 and 10 cleared. The reported cause is the lowest-numbered candidate that survives gating.
- R3: Non-delegated candidates (delegation bit 0) are gated by the machine enable. That enable is 1 when `privLvl` is below 3, or when `privLvl` is 3 and `mGie` is 1.
- R4: Delegated candidates (delegation bit 1) are gated by the supervisor enable. That enable is 1 when `privLvl` is 0, or when `privLvl` is 1 and `sGie` is 1. It is 0 when `privLvl` is 2 or 3.
- R5: With `virtOn` high, the host enable is computed like the supervisor enable but from `hostSGie`. Any base candidate (as in R2, ignoring delegation) that passes the host enable wins first. In that case `forceHost` is 1 and the cause is the lowest such bit.
- R6: With `virtOn` high and no host winner, the guest bits 2, 6 and 10 of `pendVec & enableVec` are moved to bits 1, 5 and 9. They then replace the base candidates and go through the gating of R3 and R4, using the delegation bits at 1, 5 and 9.
- R7: `forceHost` is 0 whenever `virtOn` is low or no host-level interrupt wins.
- R8: When no candidate survives, `irqValid` is 0 and `irqCause` is 0.
- R9: The cause index is correct for every single-bit and multi-bit candidate pattern across the full `XLEN` width.
- R10: With `REG_OUT`=1, the outputs reflect the inputs sampled at the preceding rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Asynchronous active-low reset |
| pendVec | input | XLEN | Interrupt pending bits |
| enableVec | input | XLEN | Interrupt enable bits |
| delegVec | input | XLEN | Delegation-to-supervisor bits |
| privLvl | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| virtOn | input | 1 | Hart is running a guest |
| mGie | input | 1 | Machine global interrupt enable |
| sGie | input | 1 | Active supervisor global interrupt enable |
| hostSGie | input | 1 | Host supervisor global enable (non-virtualized copy) |
| irqValid | output | 1 | An interrupt is selected |
| irqCause | output | $clog2(XLEN) | Index of the selected interrupt |
| forceHost | output | 1 | Selected interrupt must trap to the host supervisor |

## Verification
On every cycle, the assertions check several properties:
- The encoder's index points at a set bit with no lower set bit.
- The force flag appears only in virtualization mode and only together with a valid result.
- A guest-mode result without force always lands on slot 1, 5 or 9.
- A non-virtualized result always points at a pending, enabled, non-guest bit.

Only the bench scenarios can show the actual priority decisions:
- a host interrupt pre-empting a guest one;
- base pending bits being dropped once the guest set replaces them;
- the privilege and enable gating of delegated and non-delegated bits;
- the exact cause chosen from multi-bit patterns.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

  typedef enum logic [1:0] {
    PRIV_USER  = 2'd0,
    PRIV_SUPER = 2'd1,
    PRIV_RSVD  = 2'd2,
    PRIV_MACH  = 2'd3
  } privLvl_e;

  // guest-supervisor source positions; each drops by one when remapped
  localparam int unsigned GUEST_SOFT_POS  = 2;
  localparam int unsigned GUEST_TIMER_POS = 6;
  localparam int unsigned GUEST_EXT_POS   = 10;

  typedef struct packed {
    logic machEn;
    logic superEn;
    logic hostSuperEn;
    logic virtMode;
  } gateStrobes_t;

endpackage

// File: rtl/irq_sel_ctz.sv
module irq_sel_ctz #(
  parameter int unsigned XLEN = 64,
  localparam int unsigned IDX_W = $clog2(XLEN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [XLEN-1:0]  vecIn,
  output logic             anySet,
  output logic [IDX_W-1:0] idxOut
);

  always_comb begin
    idxOut = '0;
    for (int i = XLEN - 1; i >= 0; i--) begin
      if (vecIn[i]) idxOut = IDX_W'(i);
    end
  end

  assign anySet = |vecIn;

  // R9
  ctz_hits_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    anySet |-> vecIn[idxOut]);

  // R9
  ctz_lowest_chk: assert property (@(posedge clk) disable iff (!rstN)
    anySet |-> ((vecIn & ((XLEN'(1) << idxOut) - XLEN'(1))) == '0));

endmodule

// File: rtl/irq_sel_ctrl.sv
module irq_sel_ctrl
  import irq_sel_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [1:0]   privLvl,
  input  logic         virtOn,
  input  logic         mGie,
  input  logic         sGie,
  input  logic         hostSGie,
  output gateStrobes_t strobes
);

  privLvl_e privNow;
  assign privNow = privLvl_e'(privLvl);

  always_comb begin
    strobes.machEn      = (privNow != PRIV_MACH) || mGie;
    strobes.superEn     = (privNow == PRIV_USER) ||
                          ((privNow == PRIV_SUPER) && sGie);
    strobes.hostSuperEn = (privNow == PRIV_USER) ||
                          ((privNow == PRIV_SUPER) && hostSGie);
    strobes.virtMode    = virtOn;
  end

  // R3
  mach_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (privLvl == 2'd3 && !mGie) |-> !strobes.machEn);

  // R4
  user_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    (privLvl == 2'd0) |-> (strobes.superEn && strobes.hostSuperEn && strobes.machEn));

  // R4
  super_closed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (privLvl[1]) |-> !strobes.superEn);

endmodule

// File: rtl/irq_sel_dp.sv
module irq_sel_dp
  import irq_sel_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  localparam int unsigned IDX_W = $clog2(XLEN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [XLEN-1:0]  pendVec,
  input  logic [XLEN-1:0]  enableVec,
  input  logic [XLEN-1:0]  delegVec,
  input  gateStrobes_t     strobes,
  output logic             selValid,
  output logic [IDX_W-1:0] selCause,
  output logic             selForce
);

  localparam logic [XLEN-1:0] GUEST_MASK = (XLEN'(1) << GUEST_SOFT_POS) |
                                           (XLEN'(1) << GUEST_TIMER_POS) |
                                           (XLEN'(1) << GUEST_EXT_POS);

  logic [XLEN-1:0]  rawPend, basePend, guestPend, hostSet, activePend, finalSet;
  logic             hostHit, finHit;
  logic [IDX_W-1:0] hostIdx, finIdx;

  assign rawPend    = pendVec & enableVec;
  assign basePend   = rawPend & ~GUEST_MASK;
  assign guestPend  = (rawPend & GUEST_MASK) >> 1;
  assign hostSet    = (strobes.virtMode && strobes.hostSuperEn) ? basePend : '0;
  assign activePend = strobes.virtMode ? guestPend : basePend;
  assign finalSet   = (activePend & ~delegVec & {XLEN{strobes.machEn}}) |
                      (activePend &  delegVec & {XLEN{strobes.superEn}});

  irq_sel_ctz #(.XLEN(XLEN)) u_hostCtz (
    .clk(clk), .rstN(rstN), .vecIn(hostSet), .anySet(hostHit), .idxOut(hostIdx)
  );

  irq_sel_ctz #(.XLEN(XLEN)) u_finCtz (
    .clk(clk), .rstN(rstN), .vecIn(finalSet), .anySet(finHit), .idxOut(finIdx)
  );

  assign selForce = hostHit;
  assign selValid = hostHit | finHit;
  assign selCause = hostHit ? hostIdx : finIdx;

  // R7
  force_needs_virt_chk: assert property (@(posedge clk) disable iff (!rstN)
    selForce |-> strobes.virtMode);

  // R6
  guest_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (selValid && strobes.virtMode && !selForce) |->
      (selCause == IDX_W'(GUEST_SOFT_POS - 1) ||
       selCause == IDX_W'(GUEST_TIMER_POS - 1) ||
       selCause == IDX_W'(GUEST_EXT_POS - 1)));

  // R2
  plain_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    (selValid && !strobes.virtMode) |-> (pendVec[selCause] && enableVec[selCause] &&
                                         !GUEST_MASK[selCause]));

  // R8
  idle_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    !selValid |-> (selCause == '0 && !selForce));

endmodule

// File: rtl/virt_irq_select.sv
module virt_irq_select
  import irq_sel_pkg::*;
#(
  parameter int unsigned XLEN    = 64,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned IDX_W  = $clog2(XLEN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [XLEN-1:0]  pendVec,
  input  logic [XLEN-1:0]  enableVec,
  input  logic [XLEN-1:0]  delegVec,
  input  logic [1:0]       privLvl,
  input  logic             virtOn,
  input  logic             mGie,
  input  logic             sGie,
  input  logic             hostSGie,
  output logic             irqValid,
  output logic [IDX_W-1:0] irqCause,
  output logic             forceHost
);

  gateStrobes_t     strobes;
  logic             selValid, selForce;
  logic [IDX_W-1:0] selCause;

  irq_sel_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .privLvl(privLvl), .virtOn(virtOn),
    .mGie(mGie), .sGie(sGie), .hostSGie(hostSGie), .strobes(strobes)
  );

  irq_sel_dp #(.XLEN(XLEN)) u_dp (
    .clk(clk), .rstN(rstN), .pendVec(pendVec), .enableVec(enableVec),
    .delegVec(delegVec), .strobes(strobes), .selValid(selValid),
    .selCause(selCause), .selForce(selForce)
  );

  generate
    if (REG_OUT) begin : g_regOut
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          irqValid  <= 1'b0;
          irqCause  <= '0;
          forceHost <= 1'b0;
        end else begin
          irqValid  <= selValid;
          irqCause  <= selCause;
          forceHost <= selForce;
        end
      end

      // R7
      force_past_virt_chk: assert property (@(posedge clk) disable iff (!rstN)
        forceHost |-> ($past(virtOn) && irqValid));
    end else begin : g_combOut
      assign irqValid  = selValid;
      assign irqCause  = selCause;
      assign forceHost = selForce;
    end
  endgenerate

endmodule

// File: tb/virt_irq_select_bench.sv
module virt_irq_select_bench;

  localparam int unsigned XLEN  = 64;
  localparam int unsigned IDX_W = $clog2(XLEN);

  typedef struct packed {
    logic [XLEN-1:0]  pend;
    logic [XLEN-1:0]  en;
    logic [XLEN-1:0]  deleg;
    logic [1:0]       priv;
    logic             virt;
    logic             mg;
    logic             sg;
    logic             hsg;
    logic             expV;
    logic [IDX_W-1:0] expC;
    logic             expF;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t TBL [NVEC] = '{
    // R3 machine interrupt, machine mode, enabled
    '{64'h80, 64'h80, 64'h0, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 6'd7, 1'b0},
    // R3 machine mode, global enable low
    '{64'h80, 64'h80, 64'h0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'd0, 1'b0},
    // R4 delegated, supervisor mode, enable low
    '{64'h20, 64'h20, 64'h20, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 6'd0, 1'b0},
    // R4 delegated, supervisor mode, enable high
    '{64'h20, 64'h20, 64'h20, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 6'd5, 1'b0},
    // R4 delegated, machine mode: supervisor gate closed
    '{64'h20, 64'h20, 64'h20, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 6'd0, 1'b0},
    // R2 lowest of several wins
    '{64'hA2, 64'hA2, 64'h22, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 6'd1, 1'b0},
    // R2 guest bits masked outside virtualization
    '{64'h444, 64'h444, 64'h0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 6'd0, 1'b0},
    // R6 guest timer 6 -> 5, delegated, supervisor enabled
    '{64'h40, 64'h40, 64'h20, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 6'd5, 1'b0},
    // R6 host gate closed: base bit 9 dropped, guest 6 -> 5
    '{64'h240, 64'h240, 64'h0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 6'd5, 1'b0},
    // R5 host gate open: bit 9 wins and forces host
    '{64'h240, 64'h240, 64'h0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 6'd9, 1'b1},
    // R5 user mode opens host gate
    '{64'h2, 64'h2, 64'h0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 6'd1, 1'b1},
    // R7 same as host case but not virtualized
    '{64'h240, 64'h240, 64'h0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 6'd9, 1'b0},
    // R6 enable masks guest soft bit, guest ext 10 -> 9
    '{64'h404, 64'h400, 64'h0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 6'd9, 1'b0},
    // R9 top bit
    '{64'h8000000000000000, 64'h8000000000000000, 64'h0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0,
      1'b1, 6'd63, 1'b0}
  };

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [XLEN-1:0]  pendVec = '0, enableVec = '0, delegVec = '0;
  logic [1:0]       privLvl = 2'd0;
  logic             virtOn = 1'b0, mGie = 1'b0, sGie = 1'b0, hostSGie = 1'b0;
  logic             irqValid, forceHost;
  logic [IDX_W-1:0] irqCause;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  virt_irq_select #(.XLEN(XLEN)) u_virt_irq_select (
    .clk(clk), .rstN(rstN), .pendVec(pendVec), .enableVec(enableVec),
    .delegVec(delegVec), .privLvl(privLvl), .virtOn(virtOn), .mGie(mGie),
    .sGie(sGie), .hostSGie(hostSGie), .irqValid(irqValid),
    .irqCause(irqCause), .forceHost(forceHost)
  );

  task automatic chkOut(input string req, input logic eV, input logic [IDX_W-1:0] eC,
                        input logic eF);
    checks++;
    if (irqValid !== eV || irqCause !== eC || forceHost !== eF) begin
      fails++;
      $display("FAIL %s: actual v=%0d c=%0d f=%0d expected v=%0d c=%0d f=%0d",
               req, irqValid, irqCause, forceHost, eV, eC, eF);
    end
  endtask

  task automatic drive(input vec_t v);
    pendVec = v.pend; enableVec = v.en; delegVec = v.deleg; privLvl = v.priv;
    virtOn = v.virt; mGie = v.mg; sGie = v.sg; hostSGie = v.hsg;
  endtask

  function automatic bit isGuest(input int b);
    return (b == 2) || (b == 6) || (b == 10);
  endfunction

  initial begin
    vec_t w;
    // R1: reset holds outputs low despite a live request
    drive(TBL[0]);
    repeat (3) @(negedge clk);
    chkOut("R1", 1'b0, '0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    chkOut("R10", 1'b1, 6'd7, 1'b0);

    // R10: a new vector does not show before the next rising edge
    drive(TBL[1]);
    #1;
    chkOut("R10", 1'b1, 6'd7, 1'b0);

    for (int k = 0; k < NVEC; k++) begin
      @(negedge clk);
      drive(TBL[k]);
      @(negedge clk);
      chkOut($sformatf("R2-table entry %0d", k), TBL[k].expV, TBL[k].expC, TBL[k].expF);
    end

    // R9 single-bit walk (R2 guest bits must stay silent)
    for (int i = 0; i < XLEN; i++) begin
      w = '0;
      w.pend = XLEN'(1) << i; w.en = '1; w.priv = 2'd0;
      @(negedge clk); drive(w); @(negedge clk);
      if (isGuest(i)) chkOut("R9 walk", 1'b0, '0, 1'b0);
      else            chkOut("R9 walk", 1'b1, IDX_W'(i), 1'b0);
    end

    // R9 multi-bit: all bits from i upward
    for (int i = 0; i < XLEN; i++) begin
      int j;
      j = i;
      while (isGuest(j)) j++;
      w = '0;
      w.pend = '1 << i; w.en = '1; w.priv = 2'd0;
      @(negedge clk); drive(w); @(negedge clk);
      chkOut("R9 multi", 1'b1, IDX_W'(j), 1'b0);
    end

    // R8: nothing enabled
    w = '0; w.pend = '1; w.en = '0; w.virt = 1'b1; w.hsg = 1'b1;
    @(negedge clk); drive(w); @(negedge clk);
    chkOut("R8", 1'b0, '0, 1'b0);

    // R1: asynchronous reset clears a live result
    drive(TBL[9]);
    @(negedge clk);
    chkOut("R5", 1'b1, 6'd9, 1'b1);
    rstN = 1'b0;
    #1;
    chkOut("R1", 1'b0, '0, 1'b0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule